// File: doc/BRIEF.md
# Converter Front-End Phase Sequencer

This block times the analog front end of a converter for one channel conversion at a time. A conversion is made of up to three phases. The first is an optional presample phase, in which the sampling capacitor is tied to one of two internal reference voltages. Next comes a sample phase, in which the external input multiplexer drives the capacitor. Last is the convert phase. An enable mask selects, one bit per channel, which channels get the presample phase. A bypass control can drop the sample phase on those channels, and the level taken from the internal reference is then what gets converted.

A conversion request enters through a valid/ready handshake. `start_ready` is high only while the sequencer is idle. A request held on `start_valid` while a conversion is running is not taken, and it stays pending until the sequencer is idle again. The result side has no back-pressure. `done` is a one-cycle pulse that carries the number of cycles the conversion took, and the consumer must take it in that cycle. Phase lengths, the reference choice and the bypass control are captured at the accepting edge.

Top module: `adc_phase_seq`

## Requirements
- R1: A channel whose mask bit is clear runs a sample phase of S cycles, then a convert phase of C cycles, and `done` reports a total of S+C.
- R2: A channel whose mask bit is set runs presample for P cycles, then sample for S cycles, then convert for C cycles, in that order, for a total of P+S+C.
- R3: When `skip_sample` is 1 on a channel whose mask bit is set, the sample phase is left out. The channel runs presample then convert, for a total of P+C.
- R4: `skip_sample` has no effect on a channel whose mask bit is clear.
- R5: The presample decision for channel n is taken from bit n of `pre_en_mask`.
- R6: During presample, `pre_ref_sel` equals the `ref_sel` value captured when the request was accepted (0 selects the low internal reference, 1 the high one).
- R7: `mux_en` is 1 in exactly the sample-phase cycles, and never during presample or convert.
- R8: `conv_internal` is 1 throughout the convert phase when the sample phase was skipped, and 0 at all other times.
- R9: P, S, C, `ref_sel`, `skip_sample` and the mask bit are captured at acceptance, so later changes to them do not alter the running conversion. A length of 0 is treated as 1.
- R10: In the cycle after the last convert cycle, `done` is 1 for exactly one clock, the phase is idle, `start_ready` is 1, and `total_cycles` holds the number of active cycles. A `start_valid` asserted during a conversion is ignored.
- R11: During and right after reset, the phase is idle (`phase_onehot` = 000), `start_ready` = 1, `done` = 0, `mux_en` = 0 and `conv_internal` = 0.
- R12: `phase_onehot` has at most one bit set: bit 0 = presample, bit 1 = sample, bit 2 = convert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Conversion request valid |
| start_ready | output | 1 | Sequencer idle, request can be accepted |
| start_chan | input | CH_W | Channel number of the request |
| pre_en_mask | input | NUM_CH | Presample enable, one bit per channel |
| skip_sample | input | 1 | Drop the sample phase on presampling channels |
| ref_sel | input | 1 | Internal reference choice for presample |
| pre_cycles | input | CNT_W | Presample length P |
| samp_cycles | input | CNT_W | Sample length S |
| conv_cycles | input | CNT_W | Convert length C |
| phase_onehot | output | 3 | Current phase: bit0 presample, bit1 sample, bit2 convert |
| pre_ref_sel | output | 1 | Reference selected for the presample phase |
| mux_en | output | 1 | External input multiplexer enable |
| conv_internal | output | 1 | Convert phase is converting the internal reference level |
| done | output | 1 | One-cycle end-of-conversion pulse |
| total_cycles | output | CNT_W+2 | Active cycle count, valid with done |

## Verification
The vector table runs channels with the mask bit clear and with it set, and applies the bypass to each kind. This separates the three phase plans and shows that the bypass is ignored where presampling is off. Channels are spread over both set and clear mask bits, so that a wrong index into the mask changes the phase lengths that are observed. The lengths go down to 1 and 0 and up to the largest count, which exposes off-by-one errors and faults in zero handling and counter width. Directed runs change every control after acceptance, hold `start_valid` high while a conversion is busy, and reset in the middle of a conversion. These runs separate captured values from live ones.

// File: rtl/adc_phase_pkg.sv
`timescale 1ns/1ps
package adc_phase_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_SAMP = 2'd2,
    PH_CONV = 2'd3
  } phase_e;

  localparam int NUM_PHASES = 3;

  // slot of a phase in the length arrays: 0 presample, 1 sample, 2 convert
  function automatic int phase_slot(phase_e p);
    case (p)
      PH_PRE:  return 0;
      PH_SAMP: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [NUM_PHASES-1:0] phase_bits(phase_e p);
    case (p)
      PH_PRE:  return 3'b001;
      PH_SAMP: return 3'b010;
      PH_CONV: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/adc_phase_plan.sv
`timescale 1ns/1ps
module adc_phase_plan
  import adc_phase_pkg::*;
(
  input  logic   start_pre,
  input  logic   skip_samp,
  input  phase_e cur,
  output phase_e first_ph,
  output phase_e next_ph
);
  always_comb begin
    first_ph = start_pre ? PH_PRE : PH_SAMP;
    case (cur)
      PH_PRE:  next_ph = skip_samp ? PH_CONV : PH_SAMP;
      PH_SAMP: next_ph = PH_CONV;
      default: next_ph = PH_IDLE;
    endcase
  end
endmodule

// File: rtl/adc_phase_timer.sv
`timescale 1ns/1ps
module adc_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  input  logic             run,
  output logic             last
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        remain_q <= '0;
    else if (load)                     remain_q <= load_len - CNT_W'(1);
    else if (run && remain_q != '0)    remain_q <= remain_q - CNT_W'(1);
  end

  assign last = (remain_q == '0);
endmodule

// File: rtl/adc_phase_tally.sv
`timescale 1ns/1ps
module adc_phase_tally #(
  parameter int TOT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             finish,
  output logic             done,
  output logic [TOT_W-1:0] total
);
  logic [TOT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      done  <= 1'b0;
      total <= '0;
    end else begin
      done <= finish;
      if (clear)       run_q <= '0;
      else if (active) run_q <= run_q + TOT_W'(1);
      if (finish)      total <= run_q + TOT_W'(1);
    end
  end
endmodule

// File: rtl/adc_phase_seq.sv
`timescale 1ns/1ps
module adc_phase_seq
  import adc_phase_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 6,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int TOT_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [CH_W-1:0]  start_chan,
  input  logic [NUM_CH-1:0] pre_en_mask,
  input  logic             skip_sample,
  input  logic             ref_sel,
  input  logic [CNT_W-1:0] pre_cycles,
  input  logic [CNT_W-1:0] samp_cycles,
  input  logic [CNT_W-1:0] conv_cycles,
  output logic [2:0]       phase_onehot,
  output logic             pre_ref_sel,
  output logic             mux_en,
  output logic             conv_internal,
  output logic             done,
  output logic [TOT_W-1:0] total_cycles
);
  phase_e ph_q, first_ph, next_ph;
  logic   use_pre_in, skip_in, accept, phase_end, load, last;
  logic   skip_q, ref_q;
  logic [CNT_W-1:0] raw_len [NUM_PHASES];
  logic [CNT_W-1:0] clamp_len [NUM_PHASES];
  logic [CNT_W-1:0] len_q [NUM_PHASES];
  logic [CNT_W-1:0] load_len;

  assign raw_len[0] = pre_cycles;
  assign raw_len[1] = samp_cycles;
  assign raw_len[2] = conv_cycles;

  // zero lengths are stretched to one cycle, per phase
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_len
    assign clamp_len[g] = (raw_len[g] == '0) ? CNT_W'(1) : raw_len[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_q[g] <= CNT_W'(1);
      else if (accept) len_q[g] <= clamp_len[g];
    end
  end

  assign start_ready = (ph_q == PH_IDLE);
  assign accept      = start_valid && start_ready;
  assign use_pre_in  = pre_en_mask[start_chan];
  assign skip_in     = skip_sample && use_pre_in;

  adc_phase_plan u_plan (
    .start_pre (use_pre_in),
    .skip_samp (skip_q),
    .cur       (ph_q),
    .first_ph  (first_ph),
    .next_ph   (next_ph)
  );

  assign phase_end = (ph_q != PH_IDLE) && last;
  assign load      = accept || (phase_end && next_ph != PH_IDLE);
  assign load_len  = accept ? clamp_len[phase_slot(first_ph)]
                            : len_q[phase_slot(next_ph)];

  adc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_len (load_len),
    .run      (ph_q != PH_IDLE),
    .last     (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      skip_q <= 1'b0;
      ref_q  <= 1'b0;
    end else if (accept) begin
      ph_q   <= first_ph;
      skip_q <= skip_in;
      ref_q  <= ref_sel;
    end else if (phase_end) begin
      ph_q   <= next_ph;
    end
  end

  adc_phase_tally #(.TOT_W(TOT_W)) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .active (ph_q != PH_IDLE),
    .finish (phase_end && ph_q == PH_CONV),
    .done   (done),
    .total  (total_cycles)
  );

  assign phase_onehot  = phase_bits(ph_q);
  assign pre_ref_sel   = ref_q;
  assign mux_en        = (ph_q == PH_SAMP);
  assign conv_internal = (ph_q == PH_CONV) && skip_q;
endmodule

// File: rtl/adc_phase_seq_chk.sv
`timescale 1ns/1ps
module adc_phase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_ready,
  input logic [2:0] phase_onehot,
  input logic       pre_ref_sel,
  input logic       mux_en,
  input logic       conv_internal,
  input logic       done
);
  p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_onehot));

  p_mux_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mux_en |-> (!phase_onehot[0] && !phase_onehot[2]));

  p_internal_conv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_internal |-> phase_onehot[2]);

  p_samp_to_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_onehot[1]) |-> phase_onehot[2]);

  p_pre_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_onehot[0]) |-> (phase_onehot[1] || phase_onehot[2]));

  p_ref_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_onehot[0] && $past(phase_onehot[0])) |-> $stable(pre_ref_sel));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_conv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(phase_onehot[2]) && start_ready));

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> (phase_onehot == 3'b000));
endmodule

bind adc_phase_seq adc_phase_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_ready   (start_ready),
  .phase_onehot  (phase_onehot),
  .pre_ref_sel   (pre_ref_sel),
  .mux_en        (mux_en),
  .conv_internal (conv_internal),
  .done          (done)
);

// File: tb/adc_phase_seq_bench.sv
`timescale 1ns/1ps
module adc_phase_seq_bench;
  localparam int NUM_CH = 8;
  localparam int CNT_W  = 6;
  localparam int CH_W   = 3;
  localparam int TOT_W  = CNT_W + 2;
  localparam logic [NUM_CH-1:0] MASK = 8'b0110_1010; // channels 1,3,5,6 presample

  // {chan[2:0], skip, ref, P[5:0], S[5:0], C[5:0]}
  localparam int NV = 8;
  localparam logic [22:0] VECS [NV] = '{
    {3'd0, 1'b0, 1'b0, 6'd5,  6'd3, 6'd4 },  // R1 no presample
    {3'd1, 1'b0, 1'b1, 6'd2,  6'd3, 6'd5 },  // R2 full plan
    {3'd3, 1'b1, 1'b0, 6'd4,  6'd6, 6'd2 },  // R3 bypass
    {3'd2, 1'b1, 1'b1, 6'd3,  6'd2, 6'd2 },  // R4 bypass ignored
    {3'd7, 1'b0, 1'b1, 6'd1,  6'd1, 6'd1 },  // R5 mask top bit clear
    {3'd6, 1'b0, 1'b1, 6'd1,  6'd1, 6'd1 },  // R5 mask bit set
    {3'd5, 1'b1, 1'b1, 6'd63, 6'd9, 6'd63},  // R3 max lengths
    {3'd0, 1'b0, 1'b0, 6'd0,  6'd0, 6'd0 }   // R9 zero as one
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic start_ready;
  logic [CH_W-1:0] start_chan = '0;
  logic [NUM_CH-1:0] pre_en_mask = MASK;
  logic skip_sample = 1'b0, ref_sel = 1'b0;
  logic [CNT_W-1:0] pre_cycles = '0, samp_cycles = '0, conv_cycles = '0;
  logic [2:0] phase_onehot;
  logic pre_ref_sel, mux_en, conv_internal, done;
  logic [TOT_W-1:0] total_cycles;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_phase_seq #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_adc_phase_seq (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_chan(start_chan), .pre_en_mask(pre_en_mask), .skip_sample(skip_sample),
    .ref_sel(ref_sel), .pre_cycles(pre_cycles), .samp_cycles(samp_cycles),
    .conv_cycles(conv_cycles), .phase_onehot(phase_onehot), .pre_ref_sel(pre_ref_sel),
    .mux_en(mux_en), .conv_internal(conv_internal), .done(done),
    .total_cycles(total_cycles)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic run_conv(input int ch, input bit sk, input bit rf, input int p,
                          input int s, input int c, input bit perturb, input bit noise,
                          input string tag);
    bit up = MASK[ch];
    bit esk = sk && up;
    int ep = up ? len1(p) : 0;
    int es = esk ? 0 : len1(s);
    int ec = len1(c);
    int np = 0, ns = 0, nc = 0;
    int gap = 0, ord = 0, mux_err = 0, int_err = 0, ref_err = 0, rdy_err = 0;
    int last_pos = 0;
    bit got_done = 0;
    @(negedge clk);
    start_chan = CH_W'(ch); skip_sample = sk; ref_sel = rf;
    pre_cycles = CNT_W'(p); samp_cycles = CNT_W'(s); conv_cycles = CNT_W'(c);
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    if (perturb) begin
      pre_en_mask = ~MASK; skip_sample = ~sk; ref_sel = ~rf;
      pre_cycles = 6'd7; samp_cycles = 6'd11; conv_cycles = 6'd13;
    end
    for (int i = 0; i < 400; i++) begin
      if (i > 0) @(negedge clk);
      if (done) begin got_done = 1; break; end
      if (phase_onehot == 3'b000) gap++;
      else begin
        int pos = phase_onehot[0] ? 0 : (phase_onehot[1] ? 1 : 2);
        if (pos < last_pos) ord++;
        last_pos = pos;
      end
      if (phase_onehot[0]) np++;
      if (phase_onehot[1]) ns++;
      if (phase_onehot[2]) nc++;
      if (mux_en !== phase_onehot[1]) mux_err++;
      if (conv_internal !== (phase_onehot[2] && esk)) int_err++;
      if (phase_onehot[0] && pre_ref_sel !== rf) ref_err++;
      if (start_ready !== 1'b0) rdy_err++;
      if (noise) begin
        start_valid = 1'b1; start_chan = CH_W'(ch + 1);
        pre_cycles = 6'd2; samp_cycles = 6'd2; conv_cycles = 6'd2;
      end
    end
    start_valid = 1'b0;
    pre_en_mask = MASK;
    chk({tag, " R2 presample cycles"}, np, ep);
    chk({tag, " R1 sample cycles"}, ns, es);
    chk({tag, " R3 convert cycles"}, nc, ec);
    chk({tag, " R12 no idle gap"}, gap, 0);
    chk({tag, " R2 phase order"}, ord, 0);
    chk({tag, " R7 mux only in sample"}, mux_err, 0);
    chk({tag, " R8 internal flag"}, int_err, 0);
    chk({tag, " R6 reference select"}, ref_err, 0);
    chk({tag, " R10 busy not ready"}, rdy_err, 0);
    chk({tag, " R10 done seen"}, int'(got_done), 1);
    chk({tag, " R10 total"}, int'(total_cycles), ep + es + ec);
    chk({tag, " R10 idle at done"}, int'(phase_onehot), 0);
    chk({tag, " R10 ready at done"}, int'(start_ready), 1);
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, int'(done), 0);
    chk({tag, " R10 stays idle"}, int'(phase_onehot), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset phase", int'(phase_onehot), 0);
    chk("R11 reset ready", int'(start_ready), 1);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset mux", int'(mux_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 post-reset phase", int'(phase_onehot), 0);
    chk("R11 post-reset internal", int'(conv_internal), 0);

    for (int v = 0; v < NV; v++) begin
      logic [22:0] e = VECS[v];
      run_conv(int'(e[22:20]), e[19], e[18], int'(e[17:12]), int'(e[11:6]),
               int'(e[5:0]), 1'b0, 1'b0, $sformatf("vec%0d", v));
    end

    // R9: inputs changed after acceptance must not matter
    run_conv(1, 1'b0, 1'b1, 3, 4, 2, 1'b1, 1'b0, "R9 perturb pre");
    run_conv(0, 1'b1, 1'b0, 0, 5, 3, 1'b1, 1'b0, "R9 perturb nopre");
    // R10: start requests while busy are ignored
    run_conv(3, 1'b1, 1'b1, 5, 2, 4, 1'b0, 1'b1, "R10 noise");

    // R11: reset in the middle of a conversion
    @(negedge clk);
    start_chan = 3'd1; skip_sample = 1'b0; ref_sel = 1'b1;
    pre_cycles = 6'd3; samp_cycles = 6'd3; conv_cycles = 6'd3;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 mid-run in sample", int'(mux_en), 1);
    rst_n = 1'b0;
    #1;
    chk("R11 async reset phase", int'(phase_onehot), 0);
    chk("R11 async reset ready", int'(start_ready), 1);
    chk("R11 async reset mux", int'(mux_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R11 no done after reset", int'(done), 0);
    chk("R11 idle after reset", int'(phase_onehot), 0);

    run_conv(6, 1'b1, 1'b0, 2, 2, 2, 1'b0, 1'b0, "R3 after reset");

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R10 actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule